// File: doc/BRIEF.md
# Reload-Gated Programmable Clock Divider

This block turns a fast parent clock into one slower peripheral clock whose divide ratio is set through a small register port. Software stores a candidate ratio in a ratio word. That value stays staged and does not change the output. The divider adopts the staged ratio only after a two-step request: a per-clock reload-force bit and a global reload trigger, both in the control word, must be high together. The adoption then waits for the end of the current output period, so the output never carries a shortened pulse.

A separate enable bit in the control word gates the output. The gate only opens or closes at a period boundary, where the output is low, so every high pulse has full length. Staged values outside the supported set {4, 5, 6, 8} are dropped when the request is made. The register port is single-cycle: a write takes effect at the clock edge, and a read returns data combinationally from the addressed word.

Top module: `ratio_reload_clkdiv`

## Requirements
- R1: After reset `clk_out` is low and the output is gated off. The active ratio is 8. The control word (address 0x0) reads 0 and the ratio word (address 0x8) reads 0x0000_0800.
- R2: Only three control bits are stored: bit 1 (reload-force), bit 8 (reload trigger) and bit 25 (enable). In the ratio word only bits [13:8] are stored, and they hold the staged ratio. Reads return the last written value of the stored bits. All other bits read 0, and any other address reads 0.
- R3: With active ratio N, every output period lasts N parent cycles. The output is high for floor(N/2) cycles and low for the rest: 4 gives 2/2, 5 gives 2/3, 6 gives 3/3 and 8 gives 4/4.
- R4: A reload is requested only in the cycle in which bit 1 and bit 8 of the control word become high together. Writing the ratio word, setting bit 1 alone or setting bit 8 alone leaves the output period unchanged.
- R5: A requested ratio becomes active only at the end of a complete output period. The first high pulse under the new ratio starts right after that boundary, and no high pulse is ever shorter or longer than floor(N/2) of the ratio in force.
- R6: A reload request whose staged ratio is not 4, 5, 6 or 8 (for example 0, 7 or 63) leaves the active ratio unchanged.
- R7: The enable bit takes effect only at a period boundary, while the output is low. With enable clear, `clk_out` stays low.
- R8: A reload that has been requested is still applied at the next boundary when software clears bits 1 and 8 before that boundary arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word, combinational |
| clk_out | output | 1 | Divided and gated output clock |

## Verification
The bench uses the default parameters: a 6-bit ratio field at bits [13:8], enable offset 24 with field index 1, and trigger bit 8. With a 6-bit field, invalid codes such as 0, 7 and 63 can be written, so the rejection path can be exercised next to every supported ratio. A scoreboard measures whole output periods after each reprogramming step and compares their high and low lengths with the ratio the bench expects. A separate runt watch checks every high pulse seen during the run, including those around enable and disable writes.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Supported divide ratios.
  function automatic bit ratio_ok(input int n);
    return (n == 4) || (n == 5) || (n == 6) || (n == 8);
  endfunction

  // Number of high cycles in one output period.
  function automatic int high_len(input int n);
    return n / 2;
  endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int RAT_ADDR  = 8,
  parameter int RATIO_W   = 6,
  parameter int RATIO_LSB = 8,
  parameter int FORCE_BIT = 1,
  parameter int TRIG_BIT  = 8,
  parameter int EN_BIT    = 25,
  parameter int RST_RATIO = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               force_req,
  output logic               trig_req,
  output logic               en_req,
  output logic [RATIO_W-1:0] staged
);
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [DATA_W-1:0] CTRL_MASK = (ONE << EN_BIT) | (ONE << TRIG_BIT) | (ONE << FORCE_BIT);
  localparam logic [DATA_W-1:0] RAT_MASK  = DATA_W'((1 << RATIO_W) - 1) << RATIO_LSB;
  localparam logic [DATA_W-1:0] RAT_RST   = DATA_W'(RST_RATIO) << RATIO_LSB;

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rat_q;
  logic              hit_ctrl;
  logic              hit_rat;

  assign hit_ctrl = (addr == ADDR_W'(CTRL_ADDR));
  assign hit_rat  = (addr == ADDR_W'(RAT_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rat_q  <= RAT_RST;
    end else if (wr) begin
      if (hit_ctrl) ctrl_q <= wdata & CTRL_MASK;
      if (hit_rat)  rat_q  <= wdata & RAT_MASK;
    end
  end

  always_comb begin
    if (hit_ctrl)     rdata = ctrl_q;
    else if (hit_rat) rdata = rat_q;
    else              rdata = '0;
  end

  assign force_req = ctrl_q[FORCE_BIT];
  assign trig_req  = ctrl_q[TRIG_BIT];
  assign en_req    = ctrl_q[EN_BIT];
  assign staged    = rat_q[RATIO_LSB +: RATIO_W];
endmodule

// File: rtl/clkdiv_reload.sv
module clkdiv_reload
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               force_req,
  input  logic               trig_req,
  input  logic [RATIO_W-1:0] staged,
  input  logic               take,
  output logic               load_req,
  output logic               pend_valid,
  output logic [RATIO_W-1:0] pend_ratio
);
  logic arm;
  logic arm_q;

  assign arm      = force_req & trig_req;
  assign load_req = arm & ~arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q      <= 1'b0;
      pend_valid <= 1'b0;
      pend_ratio <= '0;
    end else begin
      arm_q <= arm;
      if (load_req && ratio_ok(int'(staged))) begin
        pend_valid <= 1'b1;
        pend_ratio <= staged;
      end else if (take) begin
        pend_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W   = 6,
  parameter int RST_RATIO = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_req,
  input  logic               pend_valid,
  input  logic [RATIO_W-1:0] pend_ratio,
  output logic               clk_out,
  output logic               period_end,
  output logic [RATIO_W-1:0] active,
  output logic               gate_on
);
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] cnt_n;
  logic [RATIO_W-1:0] act_n;
  logic               gate_n;
  logic               out_n;

  assign period_end = (cnt_q == active - RATIO_W'(1));

  always_comb begin
    if (period_end) begin
      cnt_n  = '0;
      act_n  = pend_valid ? pend_ratio : active;
      gate_n = en_req;
    end else begin
      cnt_n  = cnt_q + RATIO_W'(1);
      act_n  = active;
      gate_n = gate_on;
    end
    out_n = gate_n && (int'(cnt_n) < high_len(int'(act_n)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      active  <= RATIO_W'(RST_RATIO);
      gate_on <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      active  <= act_n;
      gate_on <= gate_n;
      clk_out <= out_n;
    end
  end
endmodule

// File: rtl/ratio_reload_clkdiv.sv
module ratio_reload_clkdiv #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int RAT_ADDR  = 8,
  parameter int RATIO_W   = 6,
  parameter int RATIO_LSB = 8,
  parameter int FIELD_IDX = 1,
  parameter int EN_OFFSET = 24,
  parameter int TRIG_BIT  = 8,
  parameter int RST_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_out
);
  localparam int FORCE_BIT = FIELD_IDX;
  localparam int EN_BIT    = FIELD_IDX + EN_OFFSET;

  // Named internal events, brought out for the checker.
  logic               force_req;
  logic               trig_req;
  logic               en_req;
  logic [RATIO_W-1:0] staged;
  logic               load_req;
  logic               pend_valid;
  logic [RATIO_W-1:0] pend_ratio;
  logic               period_end;
  logic [RATIO_W-1:0] active_ratio;
  logic               gate_on;

  clkdiv_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RAT_ADDR(RAT_ADDR),
    .RATIO_W(RATIO_W), .RATIO_LSB(RATIO_LSB), .FORCE_BIT(FORCE_BIT),
    .TRIG_BIT(TRIG_BIT), .EN_BIT(EN_BIT), .RST_RATIO(RST_RATIO)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .force_req(force_req), .trig_req(trig_req),
    .en_req(en_req), .staged(staged)
  );

  clkdiv_reload #(.RATIO_W(RATIO_W)) reload_i (
    .clk(clk), .rst_n(rst_n), .force_req(force_req), .trig_req(trig_req),
    .staged(staged), .take(period_end), .load_req(load_req),
    .pend_valid(pend_valid), .pend_ratio(pend_ratio)
  );

  clkdiv_core #(.RATIO_W(RATIO_W), .RST_RATIO(RST_RATIO)) core_i (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .pend_valid(pend_valid),
    .pend_ratio(pend_ratio), .clk_out(clk_out), .period_end(period_end),
    .active(active_ratio), .gate_on(gate_on)
  );
endmodule

// File: rtl/ratio_reload_clkdiv_chk.sv
module ratio_reload_clkdiv_chk
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clk_out,
  input logic               period_end,
  input logic [RATIO_W-1:0] active,
  input logic               gate_on,
  input logic               load_req,
  input logic               pend_valid
);
  logic [RATIO_W-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_run <= '0;
    else if (clk_out) hi_run <= hi_run + RATIO_W'(1);
    else              hi_run <= '0;
  end

  // R3, R6: the active ratio is always a supported value
  p_active_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ok(int'(active)));

  // R5: the active ratio only moves right after a period boundary
  p_reload_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> $past(period_end));

  // R5: every high pulse has the full length for the ratio in force
  p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_out) |-> (int'(hi_run) == high_len(int'(active))));

  // R5: a high pulse only starts at the beginning of a period
  p_rise_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> $past(period_end));

  // R7: the gate only switches at a boundary while the output is low
  p_gate_at_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_on) |-> ($past(period_end) && !$past(clk_out)));

  // R8: a pending reload stays until a boundary consumes it
  p_pending_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_valid) |-> $past(period_end));

  // R4: a new pending reload only appears on a request
  p_pend_on_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_valid) |-> $past(load_req));
endmodule

bind ratio_reload_clkdiv ratio_reload_clkdiv_chk #(.RATIO_W(RATIO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_out(clk_out), .period_end(period_end),
  .active(active_ratio), .gate_on(gate_on), .load_req(load_req),
  .pend_valid(pend_valid)
);

// File: tb/ratio_reload_clkdiv_tb_top.sv
module ratio_reload_clkdiv_tb_top;
  localparam int CLK_P = 10;
  localparam logic [31:0] C_EN    = 32'h0200_0000;
  localparam logic [31:0] C_FORCE = 32'h0000_0002;
  localparam logic [31:0] C_TRIG  = 32'h0000_0100;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        clk_out;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];

  // monitor state
  bit prev_out = 1'b0;
  bit started  = 1'b0;
  int hi_c = 0;
  int lo_c = 0;
  int runt_bad = 0;
  int falls = 0;

  ratio_reload_clkdiv dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // Monitor: measures whole periods (rise to rise) and pops expectations.
  always @(negedge clk) begin
    if (rst_n) begin
      if (clk_out) begin
        if (!prev_out) begin
          if (started && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " high"}, hi_c, e.hi);
            check({e.tag, " low"}, lo_c, e.lo);
          end
          started = (exp_q.size() > 0);
          hi_c = 1;
          lo_c = 0;
        end else begin
          hi_c++;
        end
      end else begin
        if (prev_out) begin
          falls++;
          if (hi_c < 2 || hi_c > 4) runt_bad++;
        end
        lo_c++;
      end
      prev_out = clk_out;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Driver: push expected periods, then wait for the monitor to drain them.
  task automatic expect_periods(input int n, input int cnt, input string tag);
    int waited;
    for (int i = 0; i < cnt; i++) begin
      exp_t e;
      e.hi = n / 2; e.lo = n - n / 2; e.tag = tag;
      exp_q.push_back(e);
    end
    waited = 0;
    while (exp_q.size() > 0 && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    if (exp_q.size() > 0) begin
      check({tag, " periods seen"}, cnt - exp_q.size(), cnt);
      exp_q.delete();
    end
  endtask

  task automatic program_ratio(input int n);
    wr(4'h8, 32'(n) << 8);
    wr(4'h0, C_EN | C_FORCE);
    wr(4'h0, C_EN | C_FORCE | C_TRIG);
    wr(4'h0, C_EN); // clear request bits before the boundary (R8)
    repeat (20) @(negedge clk);
  endtask

  task automatic count_high(input int cyc, output int highs);
    highs = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (clk_out) highs++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int highs;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 clk_out after reset", int'(clk_out), 0);
    rd(4'h0, v); check("R1 control reset", int'(v), 0);
    rd(4'h8, v); check("R1 ratio reset", int'(v), 32'h800);

    // R2 readback and reserved bits
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, v); check("R2 ratio readback", int'(v), 32'h3F00);
    wr(4'h8, 32'h0000_0800);
    rd(4'h4, v); check("R2 unmapped address", int'(v), 0);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R2 control readback", int'(v), 32'h0200_0102);
    wr(4'h0, 32'h0);
    rd(4'h0, v); check("R2 control cleared", int'(v), 0);

    // R7 disabled output stays low
    count_high(30, highs);
    check("R7 disabled output", highs, 0);

    // R1/R3 default ratio 8 after enable
    wr(4'h0, C_EN);
    expect_periods(8, 3, "R1 default ratio 8");

    // R3/R4/R8 each supported ratio via the handshake
    program_ratio(4); expect_periods(4, 3, "R3 ratio 4");
    program_ratio(5); expect_periods(5, 3, "R3 ratio 5");
    program_ratio(8); expect_periods(8, 3, "R8 ratio 8 after early clear");
    program_ratio(6); expect_periods(6, 3, "R3 ratio 6");

    // R4 staging alone, force alone, trigger alone change nothing
    wr(4'h8, 32'(4) << 8);
    repeat (20) @(negedge clk);
    expect_periods(6, 2, "R4 staged only");
    wr(4'h0, C_EN | C_FORCE); wr(4'h0, C_EN);
    repeat (20) @(negedge clk);
    expect_periods(6, 2, "R4 force only");
    wr(4'h0, C_EN | C_TRIG); wr(4'h0, C_EN);
    repeat (20) @(negedge clk);
    expect_periods(6, 2, "R4 trigger only");

    // R6 unsupported codes are dropped
    program_ratio(7);  expect_periods(6, 2, "R6 code 7");
    program_ratio(0);  expect_periods(6, 2, "R6 code 0");
    program_ratio(63); expect_periods(6, 2, "R6 code 63");

    // R4 valid request after rejected ones
    program_ratio(4); expect_periods(4, 3, "R4 ratio 4 after rejects");

    // R7 disable while high: no partial pulse, then stays low
    program_ratio(8);
    while (clk_out !== 1'b1) @(negedge clk);
    wr(4'h0, 32'h0);
    repeat (20) @(negedge clk);
    count_high(40, highs);
    check("R7 output after disable", highs, 0);
    rd(4'h0, v); check("R7 control after disable", int'(v), 0);

    // R7 re-enable mid-period: full periods only
    wr(4'h0, C_EN);
    expect_periods(8, 2, "R7 re-enable");

    // R5 no runt or stretched high pulse over the whole run
    check("R5 runt pulses", runt_bad, 0);
    check("R5 pulses observed", int'(falls > 20), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule